// File: doc/BRIEF.md
# Horizontal line sequencer for an embedded-sync 4:2:2 video output

This block produces the horizontal timing of one digital component video line carried with embedded timing codes on an 8-bit (or 10-bit) byte stream. A byte counter runs over the whole line at twice the sample rate. The sample number taken from it, called the frame position, places a narrower image window inside the 720-sample active region. The window starts at a programmable sample offset and has a programmable width in samples. An image index counts samples across the window only. It also serves as a fetch address for an external pixel source, which is asked for data through a request strobe.

On every line the output byte moves through a fixed order. The end-of-active code comes first, then blanking bytes and the start-of-active code. Inside the active region, a fill value is driven on either side of the image window, with the external pixel bytes in the window itself. One strobe pin carries either a horizontal blanking signal or a horizontal sync signal, in either polarity. Every output leaves the block a fixed two clocks after the counter value it belongs to, in every mode. Vertical timing, field generation, pixel storage and clocking belong to other blocks. The field and vertical-blanking flags for the timing codes arrive on input pins.

Top module: `bt656_hline_seq`

## Requirements
- R1: The byte counter runs from 0 to 1715 and then wraps to 0. Sample s covers bytes 2s and 2s+1, and a line is 858 samples. All line positions given below repeat on every line.
- R2: For counter bytes 1440 to 1443 the output is FF, 00, 00, XY with H=1. XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, bit 7 first. F comes from `field_i` and V comes from `vblank_i`.
- R3: For counter bytes 1712 to 1715 (samples 856 and 857) the output is FF, 00, 00, XY with H=0.
- R4: All other bytes outside the active region carry the blanking pattern: 0x80 on even bytes (chroma) and 0x10 on odd bytes (luma).
- R5: Inside the active region, a byte whose sample s satisfies off <= s < off+size and s < 720 is the byte that `pix_i` held in the clock cycle before it appears on `data_o`.
- R6: An active byte outside the image window is `dflt_c_i` on even bytes and `dflt_y_i` on odd bytes when `dflt_en_i` is 1. It is the blanking pattern of R4 when `dflt_en_i` is 0.
- R7: `img_idx_o` is 0 at sample `img_off_i` and rises by one per sample until it equals `img_size_i`, then holds that value through the next line up to the offset. After reset and before the first offset sample it reads all ones. It changes only between samples.
- R8: `pix_req_o` is high during exactly those counter bytes that fall inside the image window, two clocks before the byte appears on `data_o`.
- R9: The blanking signal is active for samples 720 to 855. When `blank_dly_i` is 1 it also stays active for samples 856 and 857, so its trailing edge moves from the start of the start-of-active code to sample 0.
- R10: The sync signal is active for `SYNC_SAMPLES` samples (default 64), starting at sample 720.
- R11: `hpin_o` carries the sync signal when `pin_sync_sel_i` is 1 and the blanking signal when it is 0. The signal is inverted when `pin_act_low_i` is 1.
- R12: `data_o` and `hpin_o` reflect the counter value from two clocks earlier, in every combination of control inputs.
- R13: While `rst_ni` is low at a clock edge, the counter goes to byte 0, `data_o` goes to 0 and `hpin_o` shows its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock, two per sample |
| rst_ni | input | 1 | Synchronous reset, active low |
| dflt_en_i | input | 1 | Drive the fill value around the image window |
| blank_dly_i | input | 1 | Hold blanking through the start-of-active code |
| pin_sync_sel_i | input | 1 | 1 selects sync, 0 selects blanking, for `hpin_o` |
| pin_act_low_i | input | 1 | Invert the strobe pin |
| field_i | input | 1 | F flag for the timing codes |
| vblank_i | input | 1 | V flag for the timing codes |
| img_off_i | input | CNT_W | First window sample |
| img_size_i | input | CNT_W | Window width in samples |
| dflt_c_i | input | DATA_W | Fill value for chroma bytes |
| dflt_y_i | input | DATA_W | Fill value for luma bytes |
| pix_i | input | DATA_W | Pixel byte, valid one clock after its request |
| data_o | output | DATA_W | Output byte stream |
| hpin_o | output | 1 | Horizontal strobe pin |
| pix_req_o | output | 1 | Pixel byte request |
| img_idx_o | output | CNT_W | Image index, aligned with `pix_req_o` |

## Verification
A wrong counter or window state does not stay hidden for long. A stray byte count moves the timing codes, and within at most one line (1716 clocks) the FF 00 00 prefix shows at the wrong time on `data_o`. A window that starts or stops at the wrong sample shows up two clocks later. Pixel bytes then appear where fill or blanking belongs, and the request strobe and image index disagree with the sample position in the same cycle. A stuck image index shows on `img_idx_o` at the next sample boundary. A wrong strobe edge shows on `hpin_o` two clocks after the counter reaches sample 720 or 856.

// File: rtl/bt656_hline_pkg.sv
package bt656_hline_pkg;

   // source of the byte that enters the output register
   typedef enum logic {
      SRC_CODE = 1'b0,
      SRC_PIX  = 1'b1
   } src_e;

   // timing-reference status byte: flags plus protection bits
   function automatic logic [7:0] xy_byte(input logic f, input logic v, input logic h);
      logic [3:0] prot;
      prot = {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
      return {1'b1, f, v, h, prot};
   endfunction

endpackage

// File: rtl/hline_byte_counter.sv
module hline_byte_counter #(
   parameter int LINE_BYTES = 1716,
   parameter int BYTE_W     = 11
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   output logic [BYTE_W-1:0] byte_o
);

   localparam logic [BYTE_W-1:0] LAST = BYTE_W'(LINE_BYTES - 1);

   logic [BYTE_W-1:0] byte_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         byte_q <= '0;
      end else if (byte_q == LAST) begin
         byte_q <= '0;
      end else begin
         byte_q <= byte_q + 1'b1;
      end
   end

   assign byte_o = byte_q;

endmodule

// File: rtl/hline_img_window.sv
module hline_img_window #(
   parameter int CNT_W          = 10,
   parameter int ACTIVE_SAMPLES = 720
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] pos_i,
   input  logic             last_byte_i,
   input  logic [CNT_W-1:0] off_i,
   input  logic [CNT_W-1:0] size_i,
   output logic [CNT_W-1:0] idx_o,
   output logic             in_win_o
);

   localparam logic [CNT_W-1:0] ACT_END = CNT_W'(ACTIVE_SAMPLES);

   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] idx_now;
   logic             below_size;

   // the index reads zero at the offset sample; otherwise the stored value
   always_comb begin
      if (pos_i == off_i) begin
         idx_now = '0;
      end else begin
         idx_now = idx_q;
      end
      below_size = (idx_now < size_i);
   end

   // advance once per sample, on its second byte, and saturate at the size
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         idx_q <= '1;
      end else if (last_byte_i) begin
         if (below_size) begin
            idx_q <= idx_now + 1'b1;
         end else begin
            idx_q <= idx_now;
         end
      end
   end

   assign idx_o    = idx_now;
   assign in_win_o = (pos_i < ACT_END) && below_size;

endmodule

// File: rtl/hline_decode.sv
module hline_decode
   import bt656_hline_pkg::*;
#(
   parameter int LINE_BYTES     = 1716,
   parameter int ACTIVE_SAMPLES = 720,
   parameter int SYNC_SAMPLES   = 64,
   parameter int BYTE_W         = 11,
   parameter int DATA_W         = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              in_win_i,
   input  logic              dflt_en_i,
   input  logic              blank_dly_i,
   input  logic              field_i,
   input  logic              vblank_i,
   input  logic [DATA_W-1:0] dflt_c_i,
   input  logic [DATA_W-1:0] dflt_y_i,
   output src_e              src_o,
   output logic [DATA_W-1:0] word_o,
   output logic              blank_o,
   output logic              sync_o
);

   localparam int PAD       = DATA_W - 8;
   localparam int ACT_BYTES = 2 * ACTIVE_SAMPLES;
   localparam logic [BYTE_W-1:0] ACT_END   = BYTE_W'(ACT_BYTES);
   localparam logic [BYTE_W-1:0] EAV_END   = BYTE_W'(ACT_BYTES + 4);
   localparam logic [BYTE_W-1:0] SAV_START = BYTE_W'(LINE_BYTES - 4);
   localparam logic [BYTE_W-1:0] SYNC_END  = BYTE_W'(ACT_BYTES + 2 * SYNC_SAMPLES);
   localparam logic [DATA_W-1:0] BLANK_C   = DATA_W'(128 * (2 ** PAD));
   localparam logic [DATA_W-1:0] BLANK_Y   = DATA_W'(16 * (2 ** PAD));

   logic [DATA_W-1:0] xy_end;
   logic [DATA_W-1:0] xy_start;

   // place the 8-bit status byte at the top of wider words
   if (PAD == 0) begin : g_narrow
      assign xy_end   = xy_byte(field_i, vblank_i, 1'b1);
      assign xy_start = xy_byte(field_i, vblank_i, 1'b0);
   end else begin : g_wide
      assign xy_end   = {xy_byte(field_i, vblank_i, 1'b1), {PAD{1'b0}}};
      assign xy_start = {xy_byte(field_i, vblank_i, 1'b0), {PAD{1'b0}}};
   end

   logic              is_active;
   logic              is_eav;
   logic              is_sav;
   logic              is_chroma;
   logic [DATA_W-1:0] blank_word;
   logic [DATA_W-1:0] code_word;
   logic [DATA_W-1:0] next_word;
   logic              next_blank;
   logic              next_sync;

   always_comb begin
      is_active  = (byte_i < ACT_END);
      is_eav     = (byte_i >= ACT_END) && (byte_i < EAV_END);
      is_sav     = (byte_i >= SAV_START);
      is_chroma  = ~byte_i[0];
      blank_word = is_chroma ? BLANK_C : BLANK_Y;

      // both code groups start on a multiple of four bytes
      unique case (byte_i[1:0])
         2'd0:    code_word = '1;
         2'd3:    code_word = is_eav ? xy_end : xy_start;
         default: code_word = '0;
      endcase

      if (is_eav || is_sav) begin
         next_word = code_word;
      end else if (is_active && !in_win_i && dflt_en_i) begin
         next_word = is_chroma ? dflt_c_i : dflt_y_i;
      end else begin
         next_word = blank_word;
      end

      next_blank = !is_active && (!is_sav || blank_dly_i);
      next_sync  = (byte_i >= ACT_END) && (byte_i < SYNC_END);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         src_o   <= SRC_CODE;
         word_o  <= '0;
         blank_o <= 1'b0;
         sync_o  <= 1'b0;
      end else begin
         src_o   <= in_win_i ? SRC_PIX : SRC_CODE;
         word_o  <= next_word;
         blank_o <= next_blank;
         sync_o  <= next_sync;
      end
   end

endmodule

// File: rtl/hline_out_stage.sv
module hline_out_stage
   import bt656_hline_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  src_e              src_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic [DATA_W-1:0] pix_i,
   input  logic              blank_i,
   input  logic              sync_i,
   input  logic              sync_sel_i,
   input  logic              act_low_i,
   output logic [DATA_W-1:0] data_o,
   output logic              pin_o
);

   logic pin_level;

   assign pin_level = (sync_sel_i ? sync_i : blank_i) ^ act_low_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         data_o <= '0;
         pin_o  <= act_low_i;
      end else begin
         data_o <= (src_i == SRC_PIX) ? pix_i : word_i;
         pin_o  <= pin_level;
      end
   end

endmodule

// File: rtl/bt656_hline_seq.sv
module bt656_hline_seq
   import bt656_hline_pkg::*;
#(
   parameter int LINE_SAMPLES   = 858,
   parameter int ACTIVE_SAMPLES = 720,
   parameter int SYNC_SAMPLES   = 64,
   parameter int DATA_W         = 8,
   parameter int CNT_W          = $clog2(LINE_SAMPLES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              dflt_en_i,
   input  logic              blank_dly_i,
   input  logic              pin_sync_sel_i,
   input  logic              pin_act_low_i,
   input  logic              field_i,
   input  logic              vblank_i,
   input  logic [CNT_W-1:0]  img_off_i,
   input  logic [CNT_W-1:0]  img_size_i,
   input  logic [DATA_W-1:0] dflt_c_i,
   input  logic [DATA_W-1:0] dflt_y_i,
   input  logic [DATA_W-1:0] pix_i,
   output logic [DATA_W-1:0] data_o,
   output logic              hpin_o,
   output logic              pix_req_o,
   output logic [CNT_W-1:0]  img_idx_o
);

   localparam int LINE_BYTES = 2 * LINE_SAMPLES;
   localparam int BYTE_W     = CNT_W + 1;

   // elaboration-time parameter checks
   if (CNT_W != $clog2(LINE_SAMPLES)) begin : g_bad_cnt_w
      $error("CNT_W must equal clog2(LINE_SAMPLES)");
   end
   if ((DATA_W != 8) && (DATA_W != 10)) begin : g_bad_data_w
      $error("DATA_W must be 8 or 10");
   end
   if ((ACTIVE_SAMPLES % 2) != 0 || (LINE_SAMPLES % 2) != 0) begin : g_bad_align
      $error("line and active sample counts must be even");
   end
   if (ACTIVE_SAMPLES + 4 > LINE_SAMPLES) begin : g_bad_active
      $error("active region leaves no room for the timing codes");
   end
   if (SYNC_SAMPLES < 1 || ACTIVE_SAMPLES + SYNC_SAMPLES > LINE_SAMPLES) begin : g_bad_sync
      $error("sync width does not fit in horizontal blanking");
   end

   logic [BYTE_W-1:0] byte_cnt;
   logic [CNT_W-1:0]  frame_pos;
   logic              in_win;
   src_e              src_q;
   logic [DATA_W-1:0] word_q;
   logic              blank_q;
   logic              sync_q;

   hline_byte_counter #(
      .LINE_BYTES (LINE_BYTES),
      .BYTE_W     (BYTE_W)
   ) i_counter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .byte_o (byte_cnt)
   );

   assign frame_pos = byte_cnt[BYTE_W-1:1];

   hline_img_window #(
      .CNT_W          (CNT_W),
      .ACTIVE_SAMPLES (ACTIVE_SAMPLES)
   ) i_window (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pos_i       (frame_pos),
      .last_byte_i (byte_cnt[0]),
      .off_i       (img_off_i),
      .size_i      (img_size_i),
      .idx_o       (img_idx_o),
      .in_win_o    (in_win)
   );

   assign pix_req_o = in_win;

   hline_decode #(
      .LINE_BYTES     (LINE_BYTES),
      .ACTIVE_SAMPLES (ACTIVE_SAMPLES),
      .SYNC_SAMPLES   (SYNC_SAMPLES),
      .BYTE_W         (BYTE_W),
      .DATA_W         (DATA_W)
   ) i_decode (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .byte_i      (byte_cnt),
      .in_win_i    (in_win),
      .dflt_en_i   (dflt_en_i),
      .blank_dly_i (blank_dly_i),
      .field_i     (field_i),
      .vblank_i    (vblank_i),
      .dflt_c_i    (dflt_c_i),
      .dflt_y_i    (dflt_y_i),
      .src_o       (src_q),
      .word_o      (word_q),
      .blank_o     (blank_q),
      .sync_o      (sync_q)
   );

   hline_out_stage #(
      .DATA_W (DATA_W)
   ) i_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_q),
      .word_i     (word_q),
      .pix_i      (pix_i),
      .blank_i    (blank_q),
      .sync_i     (sync_q),
      .sync_sel_i (pin_sync_sel_i),
      .act_low_i  (pin_act_low_i),
      .data_o     (data_o),
      .pin_o      (hpin_o)
   );

endmodule

// File: rtl/bt656_hline_seq_checker.sv
module bt656_hline_seq_checker
   import bt656_hline_pkg::*;
#(
   parameter int LINE_SAMPLES   = 858,
   parameter int ACTIVE_SAMPLES = 720,
   parameter int DATA_W         = 8,
   parameter int CNT_W          = 10
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              blank_dly_i,
   input logic [CNT_W:0]    byte_cnt,
   input logic              pix_req_o,
   input logic [CNT_W-1:0]  img_idx_o,
   input src_e              src_q,
   input logic              blank_q,
   input logic [DATA_W-1:0] data_o
);

   localparam logic [CNT_W:0] LAST_B = (CNT_W + 1)'(2 * LINE_SAMPLES - 1);
   localparam logic [CNT_W:0] ACT_B  = (CNT_W + 1)'(2 * ACTIVE_SAMPLES);
   localparam logic [CNT_W:0] SAV_B  = (CNT_W + 1)'(2 * LINE_SAMPLES - 4);

   // R1: the last byte of a line is followed by byte 0
   p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_cnt == LAST_B) |=> (byte_cnt == '0));

   // R2: the first end-of-active byte reaches the pins two clocks later as all ones
   p_eav_lead_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_cnt == ACT_B) |=> ##1 (data_o == '1));

   // R3: the last start-of-active byte carries H = 0 with the fixed top bit set
   p_sav_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_cnt == LAST_B) |=> ##1 (data_o[DATA_W-1] && !data_o[DATA_W-4]));

   // R8: a request selects the pixel path in the next stage
   p_req_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_req_o |=> (src_q == SRC_PIX));

   // R7: the index only moves between samples
   p_idx_sample_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !byte_cnt[0] |=> $stable(img_idx_o));

   // R9: blanking starts with the first byte after the active region
   p_blank_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_cnt == ACT_B) |=> blank_q);

   // R9: without the delay bit blanking ends with the start-of-active code
   p_blank_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((byte_cnt == SAV_B) && !blank_dly_i) |=> !blank_q);

   // R13: reset clears the output byte
   p_reset_data_r13: assert property (@(posedge clk_i)
      !rst_ni |=> (data_o == '0));

endmodule

bind bt656_hline_seq bt656_hline_seq_checker #(
   .LINE_SAMPLES   (LINE_SAMPLES),
   .ACTIVE_SAMPLES (ACTIVE_SAMPLES),
   .DATA_W         (DATA_W),
   .CNT_W          (CNT_W)
) i_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .blank_dly_i (blank_dly_i),
   .byte_cnt    (byte_cnt),
   .pix_req_o   (pix_req_o),
   .img_idx_o   (img_idx_o),
   .src_q       (src_q),
   .blank_q     (blank_q),
   .data_o      (data_o)
);

// File: tb/test_bt656_hline_seq.sv
module test_bt656_hline_seq;

   localparam int LINE_B  = 1716;
   localparam int ACT_S   = 720;
   localparam int SYNC_S  = 64;
   localparam int TIMEOUT = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dflt_en = 1'b0;
   logic       blank_dly = 1'b0;
   logic       sync_sel = 1'b0;
   logic       act_low = 1'b0;
   logic       fld = 1'b0;
   logic       vbl = 1'b0;
   logic [9:0] off = '0;
   logic [9:0] size = '0;
   logic [7:0] dc = '0;
   logic [7:0] dy = '0;
   logic [7:0] pix = '0;
   logic [7:0] data;
   logic       hpin;
   logic       req;
   logic [9:0] idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bt656_hline_seq i_bt656_hline_seq (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .dflt_en_i      (dflt_en),
      .blank_dly_i    (blank_dly),
      .pin_sync_sel_i (sync_sel),
      .pin_act_low_i  (act_low),
      .field_i        (fld),
      .vblank_i       (vbl),
      .img_off_i      (off),
      .img_size_i     (size),
      .dflt_c_i       (dc),
      .dflt_y_i       (dy),
      .pix_i          (pix),
      .data_o         (data),
      .hpin_o         (hpin),
      .pix_req_o      (req),
      .img_idx_o      (idx)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit in_window(input int s);
      return (s < ACT_S) && (s >= int'(off)) && (s < int'(off) + int'(size));
   endfunction

   function automatic int code_byte(input int i, input bit h);
      bit [7:0] w;
      if (i == 0) return 8'hFF;
      if (i != 3) return 8'h00;
      w = {1'b1, fld, vbl, h, vbl ^ h, fld ^ h, fld ^ vbl, fld ^ vbl ^ h};
      return int'(w);
   endfunction

   // expected byte for line position b; pv is the pixel byte offered one clock before
   function automatic int exp_data(input int b, input int pv);
      int  s;
      bit  chroma;
      s = b / 2;
      chroma = (b % 2) == 0;
      if (b >= 2 * ACT_S && b < 2 * ACT_S + 4) return code_byte(b - 2 * ACT_S, 1'b1);
      if (b >= LINE_B - 4) return code_byte(b - (LINE_B - 4), 1'b0);
      if (s < ACT_S) begin
         if (in_window(s)) return pv;
         if (dflt_en) return chroma ? int'(dc) : int'(dy);
      end
      return chroma ? 8'h80 : 8'h10;
   endfunction

   function automatic string data_tag(input int b, input int line);
      int s;
      s = b / 2;
      if (b >= 2 * ACT_S && b < 2 * ACT_S + 4) return (line > 0) ? "R1" : "R2";
      if (b >= LINE_B - 4) return (line > 0) ? "R1" : "R3";
      if (s >= ACT_S) return "R4";
      if (in_window(s)) return "R5";
      return "R6";
   endfunction

   function automatic int exp_pin(input int b);
      int s;
      bit blank_on;
      bit sync_on;
      s = b / 2;
      blank_on = (s >= ACT_S) && ((s < 856) || blank_dly);
      sync_on  = (s >= ACT_S) && (s < ACT_S + SYNC_S);
      return int'((sync_sel ? sync_on : blank_on) ^ act_low);
   endfunction

   function automatic int exp_idx(input int s, input int line);
      if (s >= int'(off)) begin
         return ((s - int'(off)) < int'(size)) ? (s - int'(off)) : int'(size);
      end
      return (line == 0) ? 1023 : int'(size);
   endfunction

   task automatic run_case(input int c_off, input int c_size, input bit c_den,
                           input bit c_dly, input bit c_ssel, input bit c_low,
                           input bit c_f, input bit c_v, input int seed);
      int  pix_last;
      string ptag;
      @(negedge clk);
      rst_n = 1'b0;
      off = 10'(c_off);
      size = 10'(c_size);
      dflt_en = c_den;
      blank_dly = c_dly;
      sync_sel = c_ssel;
      act_low = c_low;
      fld = c_f;
      vbl = c_v;
      dc = 8'(8'h5A + seed);
      dy = 8'(8'hA5 - seed);
      repeat (3) @(negedge clk);
      check(data == 8'h00, "R13 data", int'(data), 0);
      check(hpin == c_low, "R13 pin", int'(hpin), int'(c_low));
      check(req == in_window(0), "R13 req", int'(req), int'(in_window(0)));
      ptag = c_low ? "R11" : (c_ssel ? "R10" : "R9");
      rst_n = 1'b1;
      pix_last = 0;
      for (int k = 0; k < 2 * LINE_B + 8; k++) begin
         int b;
         int line;
         int pb;
         int pv;
         b = k % LINE_B;
         line = k / LINE_B;
         check(req == in_window(b / 2), "R8", int'(req), int'(in_window(b / 2)));
         check(int'(idx) == exp_idx(b / 2, line), "R7", int'(idx), exp_idx(b / 2, line));
         if (k >= 2) begin
            pb = (k - 2) % LINE_B;
            check(int'(data) == exp_data(pb, pix_last), (k == 2) ? "R12" : data_tag(pb, (k - 2) / LINE_B),
                  int'(data), exp_data(pb, pix_last));
            check(int'(hpin) == exp_pin(pb), (k == 2) ? "R12" : ptag, int'(hpin), exp_pin(pb));
         end
         pv = (k * 37 + seed * 11 + 3) % 256;
         pix = 8'(pv);
         pix_last = pv;
         @(negedge clk);
      end
   endtask

   initial begin
      run_case(8,   704, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1);
      run_case(8,   704, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2);
      run_case(0,   720, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3);
      run_case(100, 0,   1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4);
      run_case(700, 100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (TIMEOUT) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule